// File: doc/BRIEF.md
# Speculative Store Buffer with Load Forwarding

This block keeps stores that have executed but not yet retired, so that their data never reaches the data cache before the processor knows the store is real. Each slot records a tag giving the store's place in program order, its word address, its data, and two state bits: one saying the slot is occupied and one saying the store is still uncommitted. Commit and abort requests name a store by its tag. Commit clears only the uncommitted bit; abort clears the occupied bit and so throws the store away.

Loads present an address and their own sequence tag. Among the occupied slots with the same address whose store comes before the load in program order, the block picks the one closest to the load and returns its data in the same cycle. If there is no such slot, the word from the data cache is passed through. Committed slots are written to the cache through a write port with a ready handshake, one per cycle with the oldest first, and a slot is freed on the cycle its write is accepted. Sequence tags wrap around, so age is judged on the difference between two tags modulo 2^TAGW.

Top module: `spec_store_buf`

## Requirements
- R1: After reset the buffer is empty: `st_stall`=0, `cwr_valid`=0, and every load returns `ld_fwd`=0 with `ld_data` equal to `cache_rd_data`.
- R2: An accepted store (`st_valid`=1, `st_stall`=0) takes a free slot from the next cycle, holding its tag, address and data and marked uncommitted. An uncommitted slot is never offered on the cache write port.
- R3: `cm_valid` with `cm_tag` equal to the tag of an occupied, uncommitted slot marks that slot committed. From the following cycle the slot can be offered on the cache write port.
- R4: `ab_valid` with `ab_tag` equal to the tag of an occupied, uncommitted slot frees that slot. From the next cycle it no longer forwards data and is never written to the cache.
- R5: When `ld_valid`=1 and some occupied slot has the same 32-bit address and an older tag, the block sets `ld_fwd`=1 and `ld_data` to that slot's data in the same cycle. This holds whatever the cache returns, and for committed and uncommitted slots alike.
- R6: When several such slots match a load, the data comes from the one whose tag is youngest while still being older than the load tag.
- R7: Tag a is older than tag b when (b - a) mod 2^TAGW lies between 1 and 2^(TAGW-1)-1. A slot whose tag equals the load tag, or is younger than it, is ignored for forwarding, and this holds across tag wraparound.
- R8: `cwr_valid` offers the committed slot with the oldest tag, on `cwr_addr`/`cwr_data`. The offer stays unchanged while `cwr_ready`=0. The slot is freed on the cycle with `cwr_valid` and `cwr_ready` both high.
- R9: `st_stall` is 1 exactly when all DEPTH slots are occupied. A store presented while it is 1 is dropped and leaves no trace.
- R10: A load whose address matches no older slot, including an address that differs only in low bits, returns `ld_fwd`=0 and `ld_data`=`cache_rd_data`. When `ld_valid`=0, `ld_fwd` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | Store executes this cycle |
| st_tag | input | TAGW | Sequence tag of the store |
| st_addr | input | AW | Word address of the store |
| st_data | input | DW | Store data |
| st_stall | output | 1 | All slots occupied; store not accepted |
| cm_valid | input | 1 | Commit request |
| cm_tag | input | TAGW | Tag of the store to commit |
| ab_valid | input | 1 | Abort request |
| ab_tag | input | TAGW | Tag of the store to discard |
| ld_valid | input | 1 | Load lookup this cycle |
| ld_tag | input | TAGW | Sequence tag of the load |
| ld_addr | input | AW | Word address of the load |
| cache_rd_data | input | DW | Word read from the data cache for the load |
| ld_fwd | output | 1 | Load data comes from the buffer |
| ld_data | output | DW | Data returned to the load |
| cwr_valid | output | 1 | Cache write offered |
| cwr_addr | output | AW | Cache write address |
| cwr_data | output | DW | Cache write data |
| cwr_ready | input | 1 | Cache accepts the write this cycle |

## Verification
The directed phase places two stores to the same word on either side of a tag wraparound. A design that compares raw tag values, or treats an equal tag as older, then forwards the wrong word or forwards where it should not. Aborting the nearer of the two matching stores has to expose the farther one. A design that merely clears the uncommitted bit on abort would keep forwarding the discarded data, or write it to the cache later. The bench holds the cache write port not-ready while other events happen, fills every slot and then offers one more store, and runs a long pseudo-random phase of in-order commits and youngest-first aborts. These catch drains out of age order, a write offer that changes while stalled, and a dropped store that still takes a slot.

// File: rtl/ssb_pkg.sv
package ssb_pkg;

   // Selection rule used by the age picker.
   typedef enum logic {
      PICK_OLDEST   = 1'b0,
      PICK_YOUNGEST = 1'b1
   } pick_e;

endpackage

// File: rtl/ssb_free_find.sv
module ssb_free_find #(
   parameter int DEPTH = 8,
   parameter int IW    = $clog2(DEPTH)
) (
   input  logic [DEPTH-1:0] occupied,
   output logic             full,
   output logic [IW-1:0]    free_idx
);

   logic any_free;

   // Lowest-numbered empty slot wins.
   always_comb begin
      any_free = 1'b0;
      free_idx = '0;
      for (int i = DEPTH - 1; i >= 0; i--) begin
         if (!occupied[i]) begin
            any_free = 1'b1;
            free_idx = IW'(i);
         end
      end
   end

   assign full = !any_free;

endmodule

// File: rtl/ssb_age_pick.sv
module ssb_age_pick
   import ssb_pkg::*;
#(
   parameter int    DEPTH = 8,
   parameter int    TAGW  = 8,
   parameter int    IW    = $clog2(DEPTH),
   parameter pick_e MODE  = PICK_OLDEST
) (
   input  logic [DEPTH-1:0] cand,
   input  logic [TAGW-1:0]  tags [DEPTH],
   output logic             found,
   output logic [IW-1:0]    idx
);

   localparam bit WANT_YOUNG = (MODE == PICK_YOUNGEST);

   // Nonzero wrapped difference with the sign bit set means "first is older".
   function automatic logic beats(input logic [TAGW-1:0] challenger,
                                  input logic [TAGW-1:0] holder);
      logic [TAGW-1:0] diff;
      diff = WANT_YOUNG ? (holder - challenger) : (challenger - holder);
      return diff[TAGW-1];
   endfunction

   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (cand[i] && (!found || beats(tags[i], tags[idx]))) begin
            found = 1'b1;
            idx   = IW'(i);
         end
      end
   end

endmodule

// File: rtl/spec_store_buf.sv
module spec_store_buf
   import ssb_pkg::*;
#(
   parameter int DEPTH = 8,
   parameter int AW    = 32,
   parameter int DW    = 32,
   parameter int TAGW  = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            st_valid,
   input  logic [TAGW-1:0] st_tag,
   input  logic [AW-1:0]   st_addr,
   input  logic [DW-1:0]   st_data,
   output logic            st_stall,
   input  logic            cm_valid,
   input  logic [TAGW-1:0] cm_tag,
   input  logic            ab_valid,
   input  logic [TAGW-1:0] ab_tag,
   input  logic            ld_valid,
   input  logic [TAGW-1:0] ld_tag,
   input  logic [AW-1:0]   ld_addr,
   input  logic [DW-1:0]   cache_rd_data,
   output logic            ld_fwd,
   output logic [DW-1:0]   ld_data,
   output logic            cwr_valid,
   output logic [AW-1:0]   cwr_addr,
   output logic [DW-1:0]   cwr_data,
   input  logic            cwr_ready
);

   localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   // Elaboration-time parameter checks
   if (DEPTH < 2) begin : g_bad_depth
      $error("spec_store_buf: DEPTH must be at least 2");
   end
   if (TAGW < 3) begin : g_bad_tagw
      $error("spec_store_buf: TAGW must be at least 3");
   end
   if ((AW < 1) || (DW < 1)) begin : g_bad_width
      $error("spec_store_buf: AW and DW must be positive");
   end

   logic [DEPTH-1:0] valid_q;
   logic [DEPTH-1:0] spec_q;
   logic [TAGW-1:0]  tag_q  [DEPTH];
   logic [AW-1:0]    addr_q [DEPTH];
   logic [DW-1:0]    data_q [DEPTH];

   logic [DEPTH-1:0] fwd_cand;
   logic [DEPTH-1:0] drn_cand;
   logic             full;
   logic [IW-1:0]    free_idx;
   logic             alloc_we;
   logic             fwd_hit;
   logic [IW-1:0]    fwd_idx;
   logic             drn_any;
   logic [IW-1:0]    drain_idx;
   logic             drain_fire;

   ssb_free_find #(.DEPTH(DEPTH), .IW(IW)) u_free (
      .occupied (valid_q),
      .full     (full),
      .free_idx (free_idx)
   );

   // Forwarding source: youngest among older matching stores.
   ssb_age_pick #(.DEPTH(DEPTH), .TAGW(TAGW), .IW(IW), .MODE(PICK_YOUNGEST)) u_fwd_pick (
      .cand  (fwd_cand),
      .tags  (tag_q),
      .found (fwd_hit),
      .idx   (fwd_idx)
   );

   // Drain source: oldest committed store.
   ssb_age_pick #(.DEPTH(DEPTH), .TAGW(TAGW), .IW(IW), .MODE(PICK_OLDEST)) u_drn_pick (
      .cand  (drn_cand),
      .tags  (tag_q),
      .found (drn_any),
      .idx   (drain_idx)
   );

   assign alloc_we   = st_valid && !full;
   assign drain_fire = drn_any && cwr_ready;

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      logic            v_q;
      logic            s_q;
      logic [TAGW-1:0] t_q;
      logic [AW-1:0]   a_q;
      logic [DW-1:0]   d_q;
      logic            take;
      logic            kill;
      logic            retire;
      logic            leave;
      logic [TAGW-1:0] age_d;

      assign take   = alloc_we && (free_idx == IW'(g));
      assign kill   = ab_valid && v_q && s_q && (t_q == ab_tag);
      assign retire = cm_valid && v_q && s_q && (t_q == cm_tag);
      assign leave  = drain_fire && (drain_idx == IW'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v_q <= 1'b0;
            s_q <= 1'b0;
         end else if (take) begin
            v_q <= 1'b1;
            s_q <= 1'b1;
         end else if (kill) begin
            v_q <= 1'b0;
            s_q <= 1'b0;
         end else if (retire) begin
            s_q <= 1'b0;
         end else if (leave) begin
            v_q <= 1'b0;
         end
      end

      always_ff @(posedge clk) begin
         if (take) begin
            t_q <= st_tag;
            a_q <= st_addr;
            d_q <= st_data;
         end
      end

      assign age_d       = t_q - ld_tag;
      assign fwd_cand[g] = ld_valid && v_q && (a_q == ld_addr) && age_d[TAGW-1];
      assign drn_cand[g] = v_q && !s_q;

      assign valid_q[g] = v_q;
      assign spec_q[g]  = s_q;
      assign tag_q[g]   = t_q;
      assign addr_q[g]  = a_q;
      assign data_q[g]  = d_q;
   end

   assign st_stall  = full;
   assign ld_fwd    = fwd_hit;
   assign ld_data   = fwd_hit ? data_q[fwd_idx] : cache_rd_data;
   assign cwr_valid = drn_any;
   assign cwr_addr  = addr_q[drain_idx];
   assign cwr_data  = data_q[drain_idx];

endmodule

// File: rtl/ssb_checker.sv
module ssb_checker #(
   parameter int DEPTH = 8,
   parameter int IW    = 3,
   parameter int AW    = 32,
   parameter int DW    = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic [DEPTH-1:0] valid_q,
   input logic [DEPTH-1:0] spec_q,
   input logic [IW-1:0]    drain_idx,
   input logic             st_valid,
   input logic             st_stall,
   input logic             ab_valid,
   input logic             ld_valid,
   input logic             ld_fwd,
   input logic             cwr_valid,
   input logic             cwr_ready,
   input logic [AW-1:0]    cwr_addr,
   input logic [DW-1:0]    cwr_data
);

   // R2: the offered slot is an occupied, committed one
   a_r2_no_spec_drain: assert property (@(posedge clk) disable iff (!rst_n)
      cwr_valid |-> (valid_q[drain_idx] && !spec_q[drain_idx]));

   // R8: offer is held while the cache is not ready
   a_r8_offer_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (cwr_valid && !cwr_ready) |=> (cwr_valid && $stable(cwr_addr) && $stable(cwr_data)));

   // R8: an accepted write frees exactly one slot
   a_r8_free_one: assert property (@(posedge clk) disable iff (!rst_n)
      (cwr_valid && cwr_ready && !st_valid && !ab_valid)
      |=> ($countones(valid_q) == $past($countones(valid_q)) - 1));

   // R9: stall matches a full buffer
   a_r9_stall_full: assert property (@(posedge clk) disable iff (!rst_n)
      st_stall == ($countones(valid_q) == DEPTH));

   // R9: a store offered while stalled never grows occupancy
   a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      (st_stall && st_valid) |=> ($countones(valid_q) <= $past($countones(valid_q))));

   // R10: no forwarding without a load
   a_r10_fwd_gated: assert property (@(posedge clk) disable iff (!rst_n)
      ld_fwd |-> ld_valid);

endmodule

bind spec_store_buf ssb_checker #(
   .DEPTH (DEPTH),
   .IW    (IW),
   .AW    (AW),
   .DW    (DW)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .valid_q   (valid_q),
   .spec_q    (spec_q),
   .drain_idx (drain_idx),
   .st_valid  (st_valid),
   .st_stall  (st_stall),
   .ab_valid  (ab_valid),
   .ld_valid  (ld_valid),
   .ld_fwd    (ld_fwd),
   .cwr_valid (cwr_valid),
   .cwr_ready (cwr_ready),
   .cwr_addr  (cwr_addr),
   .cwr_data  (cwr_data)
);

// File: tb/spec_store_buf_tb.sv
`timescale 1ns/1ps
module spec_store_buf_tb;
   localparam int DEPTH = 8;
   localparam int AW    = 32;
   localparam int DW    = 32;
   localparam int TAGW  = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic            st_valid = 0, cm_valid = 0, ab_valid = 0, ld_valid = 0, cwr_ready = 0;
   logic [TAGW-1:0] st_tag = 0, cm_tag = 0, ab_tag = 0, ld_tag = 0;
   logic [AW-1:0]   st_addr = 0, ld_addr = 0;
   logic [DW-1:0]   st_data = 0;
   logic [DW-1:0]   cache_rd_data;
   logic            st_stall, ld_fwd, cwr_valid;
   logic [DW-1:0]   ld_data, cwr_data;
   logic [AW-1:0]   cwr_addr;

   assign cache_rd_data = ld_addr ^ 32'hC0DE_0000;

   spec_store_buf #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .TAGW(TAGW)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .st_valid(st_valid), .st_tag(st_tag), .st_addr(st_addr), .st_data(st_data), .st_stall(st_stall),
      .cm_valid(cm_valid), .cm_tag(cm_tag), .ab_valid(ab_valid), .ab_tag(ab_tag),
      .ld_valid(ld_valid), .ld_tag(ld_tag), .ld_addr(ld_addr), .cache_rd_data(cache_rd_data),
      .ld_fwd(ld_fwd), .ld_data(ld_data),
      .cwr_valid(cwr_valid), .cwr_addr(cwr_addr), .cwr_data(cwr_data), .cwr_ready(cwr_ready)
   );

   typedef struct {
      logic [7:0]  tag;
      logic [31:0] addr;
      logic [31:0] data;
      bit          spec;
   } ent_t;

   ent_t        mq[$];
   int          nchk = 0;
   int          nfail = 0;
   string       ld_req = "R5";
   string       dr_req = "R8";
   logic [7:0]  next_tag;

   function automatic bit is_older(logic [7:0] a, logic [7:0] b);
      int d;
      d = (int'(b) - int'(a) + 256) % 256;
      return (d > 0) && (d < 128);
   endfunction

   function automatic int fwd_pick();
      int best;
      best = -1;
      if (!ld_valid) return -1;
      for (int i = 0; i < mq.size(); i++) begin
         if (mq[i].addr == ld_addr && is_older(mq[i].tag, ld_tag)) begin
            if (best < 0 || is_older(mq[best].tag, mq[i].tag)) best = i;
         end
      end
      return best;
   endfunction

   function automatic int drain_pick();
      int best;
      best = -1;
      for (int i = 0; i < mq.size(); i++) begin
         if (!mq[i].spec) begin
            if (best < 0 || is_older(mq[i].tag, mq[best].tag)) best = i;
         end
      end
      return best;
   endfunction

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
      end
   endtask

   // Compare against the model, then advance one clock and update the model.
   task automatic tick();
      int f;
      int d;
      bit was_full;
      #1;
      f = fwd_pick();
      d = drain_pick();
      chk("R9", "st_stall", 32'(st_stall), 32'(mq.size() == DEPTH));
      chk(ld_req, "ld_fwd", 32'(ld_fwd), 32'(f >= 0));
      if (f >= 0) chk(ld_req, "ld_data", ld_data, mq[f].data);
      else        chk(ld_req, "ld_data", ld_data, cache_rd_data);
      chk(dr_req, "cwr_valid", 32'(cwr_valid), 32'(d >= 0));
      if (d >= 0) begin
         chk(dr_req, "cwr_addr", cwr_addr, mq[d].addr);
         chk(dr_req, "cwr_data", cwr_data, mq[d].data);
      end
      @(posedge clk);
      was_full = (mq.size() == DEPTH);
      if (d >= 0 && cwr_ready) mq.delete(d);
      if (cm_valid) begin
         for (int i = 0; i < mq.size(); i++)
            if (mq[i].spec && mq[i].tag == cm_tag) mq[i].spec = 0;
      end
      if (ab_valid) begin
         for (int i = 0; i < mq.size(); i++) begin
            if (mq[i].spec && mq[i].tag == ab_tag) begin
               mq.delete(i);
               break;
            end
         end
      end
      if (st_valid && !was_full) begin
         ent_t e;
         e.tag = st_tag; e.addr = st_addr; e.data = st_data; e.spec = 1;
         mq.push_back(e);
      end
      @(negedge clk);
   endtask

   task automatic idle_inputs();
      st_valid = 0; cm_valid = 0; ab_valid = 0; ld_valid = 0;
   endtask

   task automatic do_store(input logic [7:0] t, input logic [31:0] a, input logic [31:0] dd);
      idle_inputs();
      st_valid = 1; st_tag = t; st_addr = a; st_data = dd;
      tick();
      st_valid = 0;
   endtask

   task automatic probe(input logic [7:0] t, input logic [31:0] a);
      idle_inputs();
      ld_valid = 1; ld_tag = t; ld_addr = a;
      #0.5;
   endtask

   initial begin
      #1000000;
      nfail++;
      $display("FAIL watchdog expired, all requirements unfinished");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);

      // R1: empty after reset
      probe(8'h10, 32'h40);
      chk("R1", "st_stall", 32'(st_stall), 0);
      chk("R1", "cwr_valid", 32'(cwr_valid), 0);
      chk("R1", "ld_fwd", 32'(ld_fwd), 0);
      chk("R1", "ld_data", ld_data, 32'hC0DE_0040);
      ld_req = "R1"; dr_req = "R1";
      tick();

      // R2: three uncommitted stores, tags straddling wraparound later
      ld_req = "R2"; dr_req = "R2";
      do_store(8'hFC, 32'h40, 32'h1111_1111);
      do_store(8'hFD, 32'h40, 32'h2222_2222);
      do_store(8'hFE, 32'h80, 32'h3333_3333);
      next_tag = 8'hFF;
      probe(8'h02, 32'h40);
      chk("R2", "cwr_valid uncommitted", 32'(cwr_valid), 0);
      chk("R6", "ld_data youngest older", ld_data, 32'h2222_2222);
      chk("R5", "ld_fwd", 32'(ld_fwd), 1);
      ld_req = "R6";
      tick();

      probe(8'hFD, 32'h40);
      chk("R7", "equal tag skipped", ld_data, 32'h1111_1111);
      ld_req = "R7";
      tick();
      probe(8'hFC, 32'h40);
      chk("R7", "no older match fwd", 32'(ld_fwd), 0);
      chk("R7", "no older match data", ld_data, 32'hC0DE_0040);
      tick();
      probe(8'h02, 32'h44);
      chk("R10", "other address fwd", 32'(ld_fwd), 0);
      chk("R10", "other address data", ld_data, 32'hC0DE_0044);
      ld_req = "R10";
      tick();

      // R3: commit oldest, cache not ready
      idle_inputs();
      cm_valid = 1; cm_tag = 8'hFC; dr_req = "R3";
      tick();
      idle_inputs();
      #0.5;
      chk("R3", "cwr_valid after commit", 32'(cwr_valid), 1);
      chk("R3", "cwr_addr", cwr_addr, 32'h40);
      chk("R3", "cwr_data", cwr_data, 32'h1111_1111);
      dr_req = "R8";
      tick();
      tick();

      // R4: abort the nearer store, older one reappears
      idle_inputs();
      ab_valid = 1; ab_tag = 8'hFD;
      tick();
      probe(8'h02, 32'h40);
      chk("R4", "aborted store hidden", ld_data, 32'h1111_1111);
      ld_req = "R4";
      tick();

      // R8: drain on ready, slot freed
      idle_inputs();
      cwr_ready = 1;
      tick();
      cwr_ready = 0;
      probe(8'h02, 32'h40);
      chk("R8", "drained slot gone", ld_data, 32'hC0DE_0040);
      chk("R8", "no committed left", 32'(cwr_valid), 0);
      ld_req = "R8";
      tick();

      // R9: fill all slots, then drop one extra store
      do_store(8'hFF, 32'h100, 32'hA000_0000);
      for (int k = 0; k < 6; k++)
         do_store(8'(k), 32'h104 + 32'(4 * k), 32'hA000_0001 + 32'(k));
      #0.5;
      chk("R9", "stall when full", 32'(st_stall), 1);
      do_store(8'h06, 32'h200, 32'hDEAD_BEEF);
      probe(8'h10, 32'h200);
      chk("R9", "dropped store not forwarded", 32'(ld_fwd), 0);
      chk("R9", "still full", 32'(st_stall), 1);
      ld_req = "R9";
      tick();

      // Commit everything in order and drain
      cwr_ready = 1;
      idle_inputs(); cm_valid = 1; cm_tag = 8'hFE; tick();
      idle_inputs(); cm_valid = 1; cm_tag = 8'hFF; tick();
      for (int k = 0; k < 6; k++) begin
         idle_inputs(); cm_valid = 1; cm_tag = 8'(k); tick();
      end
      idle_inputs();
      repeat (4) tick();
      #0.5;
      chk("R8", "empty after drain", 32'(cwr_valid), 0);
      chk("R9", "no stall when empty", 32'(st_stall), 0);
      tick();

      // Pseudo-random traffic
      next_tag = 8'h07;
      ld_req = "R5"; dr_req = "R8";
      for (int n = 0; n < 3000; n++) begin
         int cm_i;
         int ab_i;
         idle_inputs();
         cm_i = -1; ab_i = -1;
         for (int i = 0; i < mq.size(); i++) begin
            if (mq[i].spec) begin
               if (cm_i < 0 || is_older(mq[i].tag, mq[cm_i].tag)) cm_i = i;
               if (ab_i < 0 || is_older(mq[ab_i].tag, mq[i].tag)) ab_i = i;
            end
         end
         if (cm_i >= 0 && ($urandom % 3) == 0) begin
            cm_valid = 1; cm_tag = mq[cm_i].tag;
         end
         if (ab_i >= 0 && ab_i != cm_i && ($urandom % 8) == 0) begin
            ab_valid = 1; ab_tag = mq[ab_i].tag;
         end
         if (($urandom % 2) == 0) begin
            st_valid = 1; st_tag = next_tag;
            st_addr = 32'h40 * 32'($urandom % 4);
            st_data = $urandom;
            if (mq.size() < DEPTH) next_tag = next_tag + 8'd1;
         end
         if (($urandom % 4) != 0) begin
            ld_valid = 1;
            ld_tag = next_tag - 8'($urandom % 12);
            ld_addr = 32'h40 * 32'($urandom % 4);
         end
         cwr_ready = (($urandom % 2) == 0);
         tick();
      end

      idle_inputs();
      cwr_ready = 0;
      tick();
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

endmodule